// File: doc/BRIEF.md
# Cycle Stamp Register Unit

This block keeps a 64-bit free-running count of core clock cycles and makes it reachable as a model-specific register at index 10h. A synchronous reset clears the count. After that it advances on every clock edge. The counter has no enable, so low-power states such as suspend or shutdown never stop it.

Three kinds of request reach the block, one per cycle, each qualified by a 2-bit request code:
- a privileged register read,
- a privileged register write,
- an unprivileged stamp read.

A request carries a 32-bit register index, a 64-bit write value split into high and low halves, the current privilege level, and a lock flag taken from a control register. Granted reads answer one cycle later on two 32-bit data outputs, marked by a valid strobe. A granted write replaces the count. A request that breaks its access rule, or names an index the block does not hold, produces a one-cycle fault pulse and has no other effect.

Top module: `cyc_stamp_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the counter to zero and drives `rsp_valid`, `fault`, `rsp_hi` and `rsp_lo` low. The first read issued in the cycle reset is released returns zero.
- R2: Outside reset, the counter advances by exactly one on every clock edge unless a write is granted on that edge. It does so through idle cycles (`req_kind` 00) and through faulting requests alike.
- R3: Register reads and writes select the counter only when `req_index` equals 10h. Any other index faults, returns no data and leaves the counter on its normal count.
- R4: A granted read answers on the next clock edge. `rsp_valid` is high for one cycle, `rsp_hi` carries bits 63:32 and `rsp_lo` carries bits 31:0 of the value the counter held at the start of the request cycle.
- R5: A granted register write (`req_kind` 10, index 10h, privilege 0) loads {`wr_hi`,`wr_lo`} in place of that cycle's increment. It raises neither `rsp_valid` nor `fault`, and counting resumes from the loaded value on the next edge.
- R6: A register read (`req_kind` 01) or register write (`req_kind` 10) is granted only at privilege level 0. At levels 1 to 3 it faults.
- R7: A stamp read (`req_kind` 11) ignores `req_index`. When `stamp_lock` is 0 it is granted at any privilege level. When `stamp_lock` is 1 it is granted only at level 0 and faults otherwise.
- R8: A faulting request raises `fault` for exactly one cycle on the next edge, with `rsp_valid` low and both data outputs zero. A faulting write does not load the counter.
- R9: The counter wraps from all ones to zero with no flag, and the carry crosses the 32-bit boundary between the halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| req_kind | input | 2 | 00 idle, 01 register read, 10 register write, 11 stamp read |
| req_index | input | 32 | Register index for register read and write |
| wr_hi | input | 32 | Upper half of the write value |
| wr_lo | input | 32 | Lower half of the write value |
| priv_lvl | input | 2 | Current privilege level, 0 most privileged |
| stamp_lock | input | 1 | Control flag restricting stamp reads to level 0 |
| rsp_valid | output | 1 | Read data valid, one cycle per granted read |
| rsp_hi | output | 32 | Upper half of the returned count |
| rsp_lo | output | 32 | Lower half of the returned count |
| fault | output | 1 | One-cycle access fault pulse |

## Verification
Every read exposes the counter in full, so a corrupted count bit, a missing carry between segments or a write that was lost or leaked shows up at the ports on the first read after the fault, one cycle after that read is issued. A wrong grant decision shows the next cycle as a missing or extra `fault` or `rsp_valid` pulse, because each request is decided on its own. Wrap and half-boundary carries are forced by loading values just below each boundary and reading on two consecutive cycles.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

   typedef enum logic [1:0] {
      KIND_IDLE   = 2'b00,
      KIND_RDREG  = 2'b01,
      KIND_WRREG  = 2'b10,
      KIND_RDSTMP = 2'b11
   } req_kind_e;

   localparam int unsigned KIND_W = 2;

endpackage

// File: rtl/stamp_counter.sv
module stamp_counter #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned SEG_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_en,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt_q
);

   localparam int unsigned NSEG = (CNT_W + SEG_W - 1) / SEG_W;

   if (SEG_W == 0 || CNT_W % SEG_W != 0) begin : g_bad_seg
      $error("stamp_counter: CNT_W must be a whole multiple of SEG_W");
   end

   logic [CNT_W-1:0] cnt_inc;

   if (NSEG <= 1) begin : g_flat
      // Single full-width adder.
      assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
   end else begin : g_seg
      // Segmented incrementer: each segment adds the AND of lower all-ones flags.
      logic [NSEG:0] carry;
      assign carry[0] = 1'b1;
      for (genvar s = 0; s < NSEG; s++) begin : g_s
         logic [SEG_W-1:0] seg_cur;
         assign seg_cur   = cnt_q[s*SEG_W +: SEG_W];
         assign carry[s+1] = carry[s] & (&seg_cur);
         assign cnt_inc[s*SEG_W +: SEG_W] = seg_cur + {{(SEG_W-1){1'b0}}, carry[s]};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (ld_en) begin
         cnt_q <= ld_val;
      end else begin
         cnt_q <= cnt_inc;
      end
   end

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(ld_en)) |-> cnt_q == $past(cnt_q) + {{(CNT_W-1){1'b0}}, 1'b1})
      else $error("counter did not advance by one"); // R2

   AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ld_en)) |-> cnt_q == $past(ld_val))
      else $error("counter did not take the written value"); // R5

endmodule

// File: rtl/stamp_gate.sv
module stamp_gate #(
   parameter int unsigned         IDX_W     = 32,
   parameter int unsigned         PRIV_W    = 2,
   parameter logic [IDX_W-1:0]    SEL_INDEX = 'h10
) (
   input  logic [stamp_pkg::KIND_W-1:0] req_kind,
   input  logic [IDX_W-1:0]             req_index,
   input  logic [PRIV_W-1:0]            priv_lvl,
   input  logic                         stamp_lock,
   output logic                         rd_ok,
   output logic                         wr_ok,
   output logic                         deny
);
   import stamp_pkg::*;

   logic is_reg, idx_hit, top_priv, stamp_ok, is_idle;

   always_comb begin
      is_idle  = (req_kind == KIND_IDLE);
      is_reg   = (req_kind == KIND_RDREG) || (req_kind == KIND_WRREG);
      idx_hit  = (req_index == SEL_INDEX);
      top_priv = (priv_lvl == '0);
      stamp_ok = !stamp_lock || top_priv;
      rd_ok    = ((req_kind == KIND_RDREG) && idx_hit && top_priv)
              || ((req_kind == KIND_RDSTMP) && stamp_ok);
      wr_ok    = (req_kind == KIND_WRREG) && idx_hit && top_priv;
      deny     = !is_idle && !rd_ok && !wr_ok;
   end

   AST_GRANT_EXCLUSIVE: assert final ($countones({rd_ok, wr_ok, deny}) <= 1)
      else $error("more than one access outcome"); // R6

   AST_REG_NEEDS_TOP: assert final (!(is_reg && !top_priv && (rd_ok || wr_ok)))
      else $error("register access granted off level 0"); // R6

endmodule

// File: rtl/stamp_resp.sv
module stamp_resp #(
   parameter int unsigned HALF_W = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                rd_ok,
   input  logic                deny,
   input  logic [2*HALF_W-1:0] cnt_q,
   output logic                rsp_valid,
   output logic [HALF_W-1:0]   rsp_hi,
   output logic [HALF_W-1:0]   rsp_lo,
   output logic                fault
);

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid <= 1'b0;
         rsp_hi    <= '0;
         rsp_lo    <= '0;
         fault     <= 1'b0;
      end else begin
         rsp_valid <= rd_ok;
         fault     <= deny;
         if (rd_ok) begin
            rsp_hi <= cnt_q[2*HALF_W-1:HALF_W];
            rsp_lo <= cnt_q[HALF_W-1:0];
         end else begin
            rsp_hi <= '0;
            rsp_lo <= '0;
         end
      end
   end

   AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
      fault |-> (!rsp_valid && rsp_hi == '0 && rsp_lo == '0))
      else $error("fault carried data"); // R8

endmodule

// File: rtl/cyc_stamp_unit.sv
module cyc_stamp_unit #(
   parameter int unsigned      HALF_W    = 32,
   parameter int unsigned      SEG_W     = 16,
   parameter int unsigned      IDX_W     = 32,
   parameter int unsigned      PRIV_W    = 2,
   parameter logic [IDX_W-1:0] SEL_INDEX = 'h10
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [stamp_pkg::KIND_W-1:0]  req_kind,
   input  logic [IDX_W-1:0]              req_index,
   input  logic [HALF_W-1:0]             wr_hi,
   input  logic [HALF_W-1:0]             wr_lo,
   input  logic [PRIV_W-1:0]             priv_lvl,
   input  logic                          stamp_lock,
   output logic                          rsp_valid,
   output logic [HALF_W-1:0]             rsp_hi,
   output logic [HALF_W-1:0]             rsp_lo,
   output logic                          fault
);
   import stamp_pkg::*;

   localparam int unsigned CNT_W = 2 * HALF_W;

   if (HALF_W < 1 || PRIV_W < 1 || IDX_W < 1) begin : g_bad_width
      $error("cyc_stamp_unit: widths must be positive");
   end

   logic             rd_ok, wr_ok, deny;
   logic [CNT_W-1:0] cnt_q;

   stamp_gate #(
      .IDX_W     (IDX_W),
      .PRIV_W    (PRIV_W),
      .SEL_INDEX (SEL_INDEX)
   ) u_gate (
      .req_kind   (req_kind),
      .req_index  (req_index),
      .priv_lvl   (priv_lvl),
      .stamp_lock (stamp_lock),
      .rd_ok      (rd_ok),
      .wr_ok      (wr_ok),
      .deny       (deny)
   );

   stamp_counter #(
      .CNT_W (CNT_W),
      .SEG_W (SEG_W)
   ) u_counter (
      .clk    (clk),
      .rst    (rst),
      .ld_en  (wr_ok),
      .ld_val ({wr_hi, wr_lo}),
      .cnt_q  (cnt_q)
   );

   stamp_resp #(
      .HALF_W (HALF_W)
   ) u_resp (
      .clk       (clk),
      .rst       (rst),
      .rd_ok     (rd_ok),
      .deny      (deny),
      .cnt_q     (cnt_q),
      .rsp_valid (rsp_valid),
      .rsp_hi    (rsp_hi),
      .rsp_lo    (rsp_lo),
      .fault     (fault)
   );

   AST_READ_VALUE: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> {rsp_hi, rsp_lo} == $past(cnt_q))
      else $error("read returned a value other than the start-of-cycle count"); // R4

   AST_PRIV_FAULT: assert property (@(posedge clk) disable iff (rst)
      ((req_kind == KIND_RDREG || req_kind == KIND_WRREG) && priv_lvl != '0) |=> (fault && !rsp_valid))
      else $error("register access off level 0 did not fault"); // R6

   AST_LOCK_FAULT: assert property (@(posedge clk) disable iff (rst)
      (req_kind == KIND_RDSTMP && stamp_lock && priv_lvl != '0) |=> (fault && !rsp_valid))
      else $error("locked stamp read off level 0 did not fault"); // R7

   AST_BAD_INDEX: assert property (@(posedge clk) disable iff (rst)
      ((req_kind == KIND_RDREG || req_kind == KIND_WRREG) && req_index != SEL_INDEX) |=> (fault && !rsp_valid))
      else $error("unknown index did not fault"); // R3

   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) |-> (!rsp_valid && !fault && rsp_hi == '0 && rsp_lo == '0))
      else $error("outputs not cleared by reset"); // R1

endmodule

// File: tb/cyc_stamp_unit_bench.sv
`timescale 1ns/1ps
module cyc_stamp_unit_bench;

   typedef struct packed {
      logic [1:0]  kind;
      logic [31:0] idx;
      logic [1:0]  priv;
      logic        lock;
      logic        e_fault;
      logic        e_valid;
   } vec_t;

   // kind: 00 idle, 01 reg read, 10 reg write, 11 stamp read
   localparam vec_t TBL [13] = '{
      '{2'b01, 32'h10, 2'd0, 1'b0, 1'b0, 1'b1},
      '{2'b01, 32'h10, 2'd3, 1'b0, 1'b1, 1'b0},
      '{2'b01, 32'h11, 2'd0, 1'b0, 1'b1, 1'b0},
      '{2'b11, 32'h0,  2'd3, 1'b0, 1'b0, 1'b1},
      '{2'b11, 32'h10, 2'd3, 1'b1, 1'b1, 1'b0},
      '{2'b11, 32'h7,  2'd0, 1'b1, 1'b0, 1'b1},
      '{2'b10, 32'h10, 2'd1, 1'b0, 1'b1, 1'b0},
      '{2'b10, 32'h0,  2'd0, 1'b0, 1'b1, 1'b0},
      '{2'b01, 32'h10, 2'd1, 1'b0, 1'b1, 1'b0},
      '{2'b10, 32'h10, 2'd0, 1'b0, 1'b0, 1'b0},
      '{2'b01, 32'h10, 2'd0, 1'b1, 1'b0, 1'b1},
      '{2'b00, 32'h10, 2'd0, 1'b0, 1'b0, 1'b0},
      '{2'b11, 32'h55, 2'd2, 1'b0, 1'b0, 1'b1}
   };
   localparam logic [63:0] TBL_WR = 64'h0000_0001_0000_0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  req_kind = 2'b00;
   logic [31:0] req_index = '0;
   logic [31:0] wr_hi = '0, wr_lo = '0;
   logic [1:0]  priv_lvl = '0;
   logic        stamp_lock = 1'b0;
   logic        rsp_valid, fault;
   logic [31:0] rsp_hi, rsp_lo;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   cyc_stamp_unit u_cyc_stamp_unit (
      .clk(clk), .rst(rst), .req_kind(req_kind), .req_index(req_index),
      .wr_hi(wr_hi), .wr_lo(wr_lo), .priv_lvl(priv_lvl), .stamp_lock(stamp_lock),
      .rsp_valid(rsp_valid), .rsp_hi(rsp_hi), .rsp_lo(rsp_lo), .fault(fault)
   );

   // Reference count built from the requirements
   logic [63:0] m_cnt, m_data;
   logic        m_rd, m_wr;
   always @(posedge clk) begin
      if (rst) begin
         m_cnt  <= '0;
         m_data <= '0;
      end else begin
         m_rd = (req_kind == 2'b01 && req_index == 32'h10 && priv_lvl == 2'd0)
             || (req_kind == 2'b11 && (!stamp_lock || priv_lvl == 2'd0));
         m_wr = (req_kind == 2'b10 && req_index == 32'h10 && priv_lvl == 2'd0);
         m_data <= m_rd ? m_cnt : 64'd0;
         m_cnt  <= m_wr ? {wr_hi, wr_lo} : m_cnt + 64'd1;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Drive at a falling edge, return at the next falling edge with outputs settled
   task automatic step(input logic [1:0] k, input logic [31:0] idx, input logic [63:0] wv,
                       input logic [1:0] pv, input logic lk);
      req_kind = k; req_index = idx; wr_hi = wv[63:32]; wr_lo = wv[31:0];
      priv_lvl = pv; stamp_lock = lk;
      @(negedge clk);
   endtask

   task automatic rd_stamp();
      step(2'b11, 32'h0, 64'd0, 2'd0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [63:0] a, v;
      repeat (3) @(negedge clk);
      chk("R1 reset clears outputs", {rsp_valid, fault, rsp_hi, rsp_lo}, '0);
      rst = 1'b0;
      rd_stamp();
      chk("R1 first read after reset", {rsp_hi, rsp_lo}, 64'd0);
      rd_stamp();
      chk("R2 second read after reset", {rsp_hi, rsp_lo}, 64'd1);
      chk("R4 valid strobe on read", {63'd0, rsp_valid}, 64'd1);

      for (int i = 0; i < 13; i++) begin
         step(TBL[i].kind, TBL[i].idx, TBL_WR, TBL[i].priv, TBL[i].lock);
         chk($sformatf("table row %0d fault R3 R6 R7 R8", i), {63'd0, fault}, {63'd0, TBL[i].e_fault});
         chk($sformatf("table row %0d valid R4 R6 R7", i), {63'd0, rsp_valid}, {63'd0, TBL[i].e_valid});
         chk($sformatf("table row %0d data R4 R5 R8", i), {rsp_hi, rsp_lo}, m_data);
      end

      // R2: idle cycles keep counting
      rd_stamp();
      a = {rsp_hi, rsp_lo};
      repeat (5) step(2'b00, 32'h0, 64'd0, 2'd0, 1'b0);
      rd_stamp();
      chk("R2 idle span counts", {rsp_hi, rsp_lo}, a + 64'd6);

      // R5: write replaces the increment
      v = 64'h1234_5678_9ABC_DEF0;
      step(2'b10, 32'h10, v, 2'd0, 1'b0);
      chk("R5 write gives no strobe", {62'd0, rsp_valid, fault}, 64'd0);
      rd_stamp();
      chk("R5 read right after write", {rsp_hi, rsp_lo}, v);
      rd_stamp();
      chk("R5 counting resumes", {rsp_hi, rsp_lo}, v + 64'd1);

      // R8 / R3: faulting writes leave the counter counting
      step(2'b10, 32'h10, 64'd0, 2'd3, 1'b0);
      chk("R8 priv write faults", {63'd0, fault}, 64'd1);
      chk("R8 fault data zero", {rsp_hi, rsp_lo}, 64'd0);
      step(2'b00, 32'h0, 64'd0, 2'd0, 1'b0);
      chk("R8 fault lasts one cycle", {63'd0, fault}, 64'd0);
      step(2'b10, 32'h11, 64'd0, 2'd0, 1'b0);
      chk("R3 unknown index faults", {63'd0, fault}, 64'd1);
      rd_stamp();
      chk("R3 R8 faulting writes not loaded", {rsp_hi, rsp_lo}, v + 64'd5);

      // R9: wrap and half-boundary carry
      step(2'b10, 32'h10, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b0);
      rd_stamp();
      chk("R9 all ones held", {rsp_hi, rsp_lo}, 64'hFFFF_FFFF_FFFF_FFFF);
      rd_stamp();
      chk("R9 wraps to zero", {rsp_hi, rsp_lo}, 64'd0);
      chk("R9 no fault on wrap", {63'd0, fault}, 64'd0);
      step(2'b10, 32'h10, 64'h0000_0000_FFFF_FFFF, 2'd0, 1'b0);
      rd_stamp();
      chk("R9 low half all ones", {rsp_hi, rsp_lo}, 64'h0000_0000_FFFF_FFFF);
      rd_stamp();
      chk("R9 carry into high half", {rsp_hi, rsp_lo}, 64'h0000_0001_0000_0000);

      // R1: reset mid-run clears the count
      rst = 1'b1;
      step(2'b00, 32'h0, 64'd0, 2'd0, 1'b0);
      rst = 1'b0;
      rd_stamp();
      chk("R1 count cleared by reset", {rsp_hi, rsp_lo}, 64'd0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule